// File: doc/BRIEF.md
# Many-to-One Write Reduction Merger

This block sits on the write side of a small interconnect with several upstream producer ports and one downstream consumer port. Each producer that joins a reduction issues its own single-beat write, flagged as a reduction and carrying a participant mask and an operator code. The block holds each contribution until every port named in the mask has delivered its write. It then combines all contributed data element-wise and forwards exactly one merged write downstream. The single downstream write response is copied back to every participating producer, and each port takes its copy with its own handshake.

Writes without the reduction flag skip the merge path. They go downstream one at a time in fixed priority order, but only while no merged write or its response is outstanding. A reduction whose contributors disagree on address, mask or operator is not forwarded. Every participant gets an error response instead.

Every data-carrying interface uses valid/ready. A source holds valid and its payload steady until ready is seen at a clock edge. Address and data of one write are accepted independently of each other. Back-pressure on an upstream port lasts from the moment its write is taken until its own response is accepted. Downstream, the block keeps valid and payload of the address and data channels stable while ready is low. The block accepts the downstream response only after both of those channels have completed.

Top module: `wr_reduce_merge`

## Requirements
- R1: After reset every upstream address and data ready is high, and every upstream response valid and both downstream request valids are low.
- R2: Once a port's address (or data) beat is accepted, that port's address (or data) ready stays low and the captured fields stay unchanged until that port accepts a response.
- R3: A write with the reduction flag set to 1 is held. The leader is the lowest-index port holding a flagged address. Its mask (bit i means port i, the leader itself always included) gives the participants. Nothing is sent downstream until every participant has delivered both its flagged address and its data.
- R4: The merged write carries the common address, and its data is the fold over all participants of the operator code: 2'b00 add modulo 2^DATA_W, 2'b01 bitwise AND, 2'b10 bitwise OR, 2'b11 unsigned maximum.
- R5: Each reduction produces exactly one downstream address beat and one data beat. Each downstream valid holds with a stable payload until accepted. No upstream response is pending while a downstream request is being offered.
- R6: The downstream response code is copied unchanged to every participant, once each. A port outside the participant set receives nothing.
- R7: Each upstream response valid stays high with a stable code until that port's own ready is seen. Other ports' responses are not affected.
- R8: If any participant's address, mask or operator differs from the leader's, or the leader's mask omits the leader, no downstream write is issued. Each participant receives response code 2'b10.
- R9: A write with the reduction flag 0 is forwarded unchanged and its response goes back to the issuing port only. This also happens while a reduction is still collecting contributions.
- R10: Among waiting unflagged writes the lowest port index goes first. When a reduction becomes complete in the same cycle that an unflagged write is waiting, the reduction goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_aw_valid | input | N_PORTS | Per-port address valid |
| up_aw_ready | output | N_PORTS | Per-port address ready |
| up_aw_addr | input | N_PORTS*ADDR_W | Per-port write address, port i in slice i |
| up_aw_red | input | N_PORTS | Per-port reduction flag |
| up_aw_mask | input | N_PORTS*N_PORTS | Per-port participant mask |
| up_aw_op | input | 2*N_PORTS | Per-port operator code |
| up_w_valid | input | N_PORTS | Per-port data valid |
| up_w_ready | output | N_PORTS | Per-port data ready |
| up_w_data | input | N_PORTS*DATA_W | Per-port write data |
| up_b_valid | output | N_PORTS | Per-port response valid |
| up_b_ready | input | N_PORTS | Per-port response ready |
| up_b_resp | output | 2*N_PORTS | Per-port response code |
| dn_aw_valid | output | 1 | Downstream address valid |
| dn_aw_ready | input | 1 | Downstream address ready |
| dn_aw_addr | output | ADDR_W | Downstream address |
| dn_w_valid | output | 1 | Downstream data valid |
| dn_w_ready | input | 1 | Downstream data ready |
| dn_w_data | output | DATA_W | Downstream data |
| dn_b_valid | input | 1 | Downstream response valid |
| dn_b_ready | output | 1 | Downstream response ready |
| dn_b_resp | input | 2 | Downstream response code |

## Verification
Completion of a reduction and the arrival of an unflagged write can land in the same clock edge. The bench provokes this by presenting the last contributor and an unflagged write from another port at the same negative edge. It then requires the merged write to appear downstream before the unflagged one. A second overlap is the response fan-out, where some participants accept their copy while others still hold back ready. The bench raises the upstream ready signals one port per cycle and checks each pending response valid before releasing it, and it also toggles the downstream data ready so the address and data beats complete in different cycles.

// File: rtl/rm_pkg.sv
package rm_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_AND = 2'b01,
    OP_OR  = 2'b10,
    OP_MAX = 2'b11
  } rm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_RESP
  } rm_state_e;

  localparam logic [1:0] RESP_SLVERR = 2'b10;

endpackage

// File: rtl/rm_ingress.sv
module rm_ingress #(
  parameter int N_PORTS = 3,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               aw_valid_i,
  output logic               aw_ready_o,
  input  logic [ADDR_W-1:0]  aw_addr_i,
  input  logic               aw_red_i,
  input  logic [N_PORTS-1:0] aw_mask_i,
  input  logic [1:0]         aw_op_i,
  input  logic               w_valid_i,
  output logic               w_ready_o,
  input  logic [DATA_W-1:0]  w_data_i,
  input  logic               release_i,
  output logic               have_aw_o,
  output logic               have_w_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               red_o,
  output logic [N_PORTS-1:0] mask_o,
  output logic [1:0]         op_o,
  output logic [DATA_W-1:0]  data_o
);

  logic               have_aw_q, have_w_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               red_q;
  logic [N_PORTS-1:0] mask_q;
  logic [1:0]         op_q;
  logic [DATA_W-1:0]  data_q;

  assign aw_ready_o = !have_aw_q;
  assign w_ready_o  = !have_w_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_aw_q <= 1'b0;
      have_w_q  <= 1'b0;
      addr_q    <= '0;
      red_q     <= 1'b0;
      mask_q    <= '0;
      op_q      <= '0;
      data_q    <= '0;
    end else if (release_i) begin
      have_aw_q <= 1'b0;
      have_w_q  <= 1'b0;
    end else begin
      if (aw_valid_i && !have_aw_q) begin
        have_aw_q <= 1'b1;
        addr_q    <= aw_addr_i;
        red_q     <= aw_red_i;
        mask_q    <= aw_mask_i;
        op_q      <= aw_op_i;
      end
      if (w_valid_i && !have_w_q) begin
        have_w_q <= 1'b1;
        data_q   <= w_data_i;
      end
    end
  end

  assign have_aw_o = have_aw_q;
  assign have_w_o  = have_w_q;
  assign addr_o    = addr_q;
  assign red_o     = red_q;
  assign mask_o    = mask_q;
  assign op_o      = op_q;
  assign data_o    = data_q;

  // R2
  aw_held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (have_aw_q && !release_i) |=> (have_aw_q && $stable(addr_q) && $stable(mask_q) && $stable(op_q)));

  // R2
  w_held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (have_w_q && !release_i) |=> (have_w_q && $stable(data_q)));

endmodule

// File: rtl/rm_merge.sv
module rm_merge
  import rm_pkg::*;
#(
  parameter int N_PORTS = 3,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16
) (
  input  logic [N_PORTS-1:0]         have_aw_i,
  input  logic [N_PORTS-1:0]         have_w_i,
  input  logic [N_PORTS-1:0]         red_i,
  input  logic [N_PORTS*ADDR_W-1:0]  addr_i,
  input  logic [N_PORTS*N_PORTS-1:0] mask_i,
  input  logic [2*N_PORTS-1:0]       op_i,
  input  logic [N_PORTS*DATA_W-1:0]  data_i,
  output logic                       red_ready_o,
  output logic                       red_err_o,
  output logic [N_PORTS-1:0]         red_part_o,
  output logic [ADDR_W-1:0]          red_addr_o,
  output logic [DATA_W-1:0]          red_data_o,
  output logic                       uni_valid_o,
  output logic [N_PORTS-1:0]         uni_sel_o,
  output logic [ADDR_W-1:0]          uni_addr_o,
  output logic [DATA_W-1:0]          uni_data_o
);

  localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

  function automatic logic [DATA_W-1:0] op_seed(rm_op_e op);
    return (op == OP_AND) ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
  endfunction

  function automatic logic [DATA_W-1:0] op_apply(rm_op_e op, logic [DATA_W-1:0] a,
                                                 logic [DATA_W-1:0] b);
    case (op)
      OP_ADD:  return a + b;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      default: return (a > b) ? a : b;
    endcase
  endfunction

  logic [N_PORTS-1:0] full;
  logic               lead_found;
  logic [IDX_W-1:0]   lead;
  logic [N_PORTS-1:0] lead_mask;
  logic [ADDR_W-1:0]  lead_addr;
  rm_op_e             lead_op;
  logic [N_PORTS-1:0] part;
  logic               all_in, err;
  logic [DATA_W-1:0]  acc;
  logic [IDX_W-1:0]   uni_idx;
  logic               uni_found;

  always_comb begin
    full       = have_aw_i & have_w_i;
    lead_found = 1'b0;
    lead       = '0;
    for (int i = N_PORTS - 1; i >= 0; i--) begin
      if (have_aw_i[i] && red_i[i]) begin
        lead_found = 1'b1;
        lead       = IDX_W'(i);
      end
    end
    lead_mask  = mask_i[lead*N_PORTS +: N_PORTS];
    lead_addr  = addr_i[lead*ADDR_W +: ADDR_W];
    lead_op    = rm_op_e'(op_i[lead*2 +: 2]);
    part       = lead_mask;
    part[lead] = 1'b1;
    all_in     = lead_found;
    err        = !lead_mask[lead];
    acc        = op_seed(lead_op);
    for (int j = 0; j < N_PORTS; j++) begin
      if (part[j]) begin
        if (!(full[j] && red_i[j])) all_in = 1'b0;
        if (addr_i[j*ADDR_W +: ADDR_W] != lead_addr) err = 1'b1;
        if (mask_i[j*N_PORTS +: N_PORTS] != lead_mask) err = 1'b1;
        if (op_i[j*2 +: 2] != lead_op) err = 1'b1;
        acc = op_apply(lead_op, acc, data_i[j*DATA_W +: DATA_W]);
      end
    end
  end

  assign red_ready_o = all_in;
  assign red_err_o   = err;
  assign red_part_o  = part;
  assign red_addr_o  = lead_addr;
  assign red_data_o  = acc;

  always_comb begin
    uni_found = 1'b0;
    uni_idx   = '0;
    for (int i = N_PORTS - 1; i >= 0; i--) begin
      if (full[i] && !red_i[i]) begin
        uni_found = 1'b1;
        uni_idx   = IDX_W'(i);
      end
    end
    uni_sel_o = '0;
    if (uni_found) uni_sel_o[uni_idx] = 1'b1;
  end

  assign uni_valid_o = uni_found;
  assign uni_addr_o  = addr_i[uni_idx*ADDR_W +: ADDR_W];
  assign uni_data_o  = data_i[uni_idx*DATA_W +: DATA_W];

endmodule

// File: rtl/rm_fanout.sv
module rm_fanout #(
  parameter int N_PORTS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [N_PORTS-1:0]   load_mask_i,
  input  logic [1:0]           load_resp_i,
  input  logic [N_PORTS-1:0]   b_ready_i,
  output logic [N_PORTS-1:0]   b_valid_o,
  output logic [2*N_PORTS-1:0] b_resp_o,
  output logic                 busy_o
);

  logic [N_PORTS-1:0] valid_q;

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    logic [1:0] resp_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        resp_q     <= '0;
      end else if (load_i && load_mask_i[g]) begin
        valid_q[g] <= 1'b1;
        resp_q     <= load_resp_i;
      end else if (valid_q[g] && b_ready_i[g]) begin
        valid_q[g] <= 1'b0;
      end
    end

    assign b_resp_o[2*g +: 2] = resp_q;

    // R7
    b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b_valid_o[g] && !b_ready_i[g]) |=> (b_valid_o[g] && $stable(b_resp_o[2*g +: 2])));
  end

  assign b_valid_o = valid_q;
  assign busy_o    = |valid_q;

  // R6
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !busy_o);

endmodule

// File: rtl/wr_reduce_merge.sv
module wr_reduce_merge
  import rm_pkg::*;
#(
  parameter int N_PORTS = 3,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_PORTS-1:0]         up_aw_valid,
  output logic [N_PORTS-1:0]         up_aw_ready,
  input  logic [N_PORTS*ADDR_W-1:0]  up_aw_addr,
  input  logic [N_PORTS-1:0]         up_aw_red,
  input  logic [N_PORTS*N_PORTS-1:0] up_aw_mask,
  input  logic [2*N_PORTS-1:0]       up_aw_op,
  input  logic [N_PORTS-1:0]         up_w_valid,
  output logic [N_PORTS-1:0]         up_w_ready,
  input  logic [N_PORTS*DATA_W-1:0]  up_w_data,
  output logic [N_PORTS-1:0]         up_b_valid,
  input  logic [N_PORTS-1:0]         up_b_ready,
  output logic [2*N_PORTS-1:0]       up_b_resp,
  output logic                       dn_aw_valid,
  input  logic                       dn_aw_ready,
  output logic [ADDR_W-1:0]          dn_aw_addr,
  output logic                       dn_w_valid,
  input  logic                       dn_w_ready,
  output logic [DATA_W-1:0]          dn_w_data,
  input  logic                       dn_b_valid,
  output logic                       dn_b_ready,
  input  logic [1:0]                 dn_b_resp
);

  logic [N_PORTS-1:0]         have_aw, have_w, cap_red, rel;
  logic [N_PORTS*ADDR_W-1:0]  cap_addr;
  logic [N_PORTS*N_PORTS-1:0] cap_mask;
  logic [2*N_PORTS-1:0]       cap_op;
  logic [N_PORTS*DATA_W-1:0]  cap_data;

  assign rel = up_b_valid & up_b_ready;

  for (genvar g = 0; g < N_PORTS; g++) begin : g_in
    rm_ingress #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_in (
      .clk        (clk),
      .rst_n      (rst_n),
      .aw_valid_i (up_aw_valid[g]),
      .aw_ready_o (up_aw_ready[g]),
      .aw_addr_i  (up_aw_addr[g*ADDR_W +: ADDR_W]),
      .aw_red_i   (up_aw_red[g]),
      .aw_mask_i  (up_aw_mask[g*N_PORTS +: N_PORTS]),
      .aw_op_i    (up_aw_op[2*g +: 2]),
      .w_valid_i  (up_w_valid[g]),
      .w_ready_o  (up_w_ready[g]),
      .w_data_i   (up_w_data[g*DATA_W +: DATA_W]),
      .release_i  (rel[g]),
      .have_aw_o  (have_aw[g]),
      .have_w_o   (have_w[g]),
      .addr_o     (cap_addr[g*ADDR_W +: ADDR_W]),
      .red_o      (cap_red[g]),
      .mask_o     (cap_mask[g*N_PORTS +: N_PORTS]),
      .op_o       (cap_op[2*g +: 2]),
      .data_o     (cap_data[g*DATA_W +: DATA_W])
    );
  end

  logic               red_ready, red_err, uni_valid;
  logic [N_PORTS-1:0] red_part, uni_sel;
  logic [ADDR_W-1:0]  red_addr, uni_addr;
  logic [DATA_W-1:0]  red_data, uni_data;

  rm_merge #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_merge (
    .have_aw_i   (have_aw),
    .have_w_i    (have_w),
    .red_i       (cap_red),
    .addr_i      (cap_addr),
    .mask_i      (cap_mask),
    .op_i        (cap_op),
    .data_i      (cap_data),
    .red_ready_o (red_ready),
    .red_err_o   (red_err),
    .red_part_o  (red_part),
    .red_addr_o  (red_addr),
    .red_data_o  (red_data),
    .uni_valid_o (uni_valid),
    .uni_sel_o   (uni_sel),
    .uni_addr_o  (uni_addr),
    .uni_data_o  (uni_data)
  );

  rm_state_e          state_q;
  logic [N_PORTS-1:0] tgt_q;
  logic [ADDR_W-1:0]  out_addr_q;
  logic [DATA_W-1:0]  out_data_q;
  logic               aw_done_q, w_done_q;
  logic               aw_hs, w_hs;
  logic               fan_load, fan_busy;
  logic [N_PORTS-1:0] fan_mask;
  logic [1:0]         fan_resp;

  assign dn_aw_valid = (state_q == ST_SEND) && !aw_done_q;
  assign dn_w_valid  = (state_q == ST_SEND) && !w_done_q;
  assign dn_aw_addr  = out_addr_q;
  assign dn_w_data   = out_data_q;
  assign dn_b_ready  = (state_q == ST_WAIT);
  assign aw_hs       = dn_aw_valid && dn_aw_ready;
  assign w_hs        = dn_w_valid && dn_w_ready;

  always_comb begin
    fan_load = 1'b0;
    fan_mask = tgt_q;
    fan_resp = dn_b_resp;
    if (state_q == ST_IDLE && red_ready && red_err) begin
      fan_load = 1'b1;
      fan_mask = red_part;
      fan_resp = RESP_SLVERR;
    end else if (state_q == ST_WAIT && dn_b_valid) begin
      fan_load = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      tgt_q      <= '0;
      out_addr_q <= '0;
      out_data_q <= '0;
      aw_done_q  <= 1'b0;
      w_done_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          aw_done_q <= 1'b0;
          w_done_q  <= 1'b0;
          if (red_ready) begin
            tgt_q <= red_part;
            if (red_err) begin
              state_q <= ST_RESP;
            end else begin
              out_addr_q <= red_addr;
              out_data_q <= red_data;
              state_q    <= ST_SEND;
            end
          end else if (uni_valid) begin
            tgt_q      <= uni_sel;
            out_addr_q <= uni_addr;
            out_data_q <= uni_data;
            state_q    <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (aw_hs) aw_done_q <= 1'b1;
          if (w_hs)  w_done_q  <= 1'b1;
          if ((aw_done_q || aw_hs) && (w_done_q || w_hs)) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (dn_b_valid) state_q <= ST_RESP;
        end
        default: begin
          if (!fan_busy) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  rm_fanout #(.N_PORTS(N_PORTS)) u_fan (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (fan_load),
    .load_mask_i (fan_mask),
    .load_resp_i (fan_resp),
    .b_ready_i   (up_b_ready),
    .b_valid_o   (up_b_valid),
    .b_resp_o    (up_b_resp),
    .busy_o      (fan_busy)
  );

  // R5
  dn_aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_aw_valid && !dn_aw_ready) |=> (dn_aw_valid && $stable(dn_aw_addr)));

  // R5
  dn_w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_w_valid && !dn_w_ready) |=> (dn_w_valid && $stable(dn_w_data)));

  // R5
  send_fan_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_aw_valid || dn_w_valid) |-> (up_b_valid == '0));

  // R5
  b_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_b_ready |-> (!dn_aw_valid && !dn_w_valid));

  for (genvar g = 0; g < N_PORTS; g++) begin : g_chk
    // R2
    stall_until_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_b_valid[g] |-> (!up_aw_ready[g] && !up_w_ready[g]));
  end

endmodule

// File: tb/sim_wr_reduce_merge.sv
module sim_wr_reduce_merge;

  localparam int N = 3;
  localparam int A = 16;
  localparam int D = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   up_aw_valid, up_aw_ready, up_aw_red, up_w_valid, up_w_ready;
  logic [N-1:0]   up_b_valid, up_b_ready;
  logic [N*A-1:0] up_aw_addr;
  logic [N*N-1:0] up_aw_mask;
  logic [2*N-1:0] up_aw_op, up_b_resp;
  logic [N*D-1:0] up_w_data;
  logic           dn_aw_valid, dn_aw_ready, dn_w_valid, dn_w_ready, dn_b_valid, dn_b_ready;
  logic [A-1:0]   dn_aw_addr;
  logic [D-1:0]   dn_w_data;
  logic [1:0]     dn_b_resp;

  always #10 clk = ~clk;

  wr_reduce_merge #(.N_PORTS(N), .ADDR_W(A), .DATA_W(D)) u0 (.*);

  int n_chk = 0, n_err = 0;
  int mon_aw_cnt = 0, mon_w_cnt = 0, rsp_sent = 0;
  int b_cnt[N];
  logic [1:0] b_last[N];
  logic [A-1:0] log_a[256];
  logic [D-1:0] log_d[256];
  logic [1:0] rsp_next = 2'b00;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial for (int i = 0; i < N; i++) b_cnt[i] = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (dn_aw_valid && dn_aw_ready) begin
        log_a[mon_aw_cnt & 255] <= dn_aw_addr;
        mon_aw_cnt <= mon_aw_cnt + 1;
      end
      if (dn_w_valid && dn_w_ready) begin
        log_d[mon_w_cnt & 255] <= dn_w_data;
        mon_w_cnt <= mon_w_cnt + 1;
      end
      for (int i = 0; i < N; i++)
        if (up_b_valid[i] && up_b_ready[i]) begin
          b_cnt[i]  <= b_cnt[i] + 1;
          b_last[i] <= up_b_resp[2*i +: 2];
        end
    end
  end

  // downstream: address always ready, data ready toggles every cycle
  initial begin dn_aw_ready = 1'b1; dn_w_ready = 1'b0; end
  always @(negedge clk) dn_w_ready = ~dn_w_ready;

  // downstream responder
  initial begin
    dn_b_valid = 1'b0;
    dn_b_resp  = 2'b00;
    forever begin
      @(negedge clk);
      if (mon_aw_cnt > rsp_sent && mon_w_cnt > rsp_sent) begin
        dn_b_valid = 1'b1;
        dn_b_resp  = rsp_next;
        while (!dn_b_ready) @(negedge clk);
        @(negedge clk);
        dn_b_valid = 1'b0;
        rsp_sent++;
      end
    end
  end

  function automatic logic [D-1:0] pat(int seed, int i);
    return D'((seed * 40503 + i * 9973 + 7) ^ (seed << i) ^ (i * 16'h5a5a));
  endfunction

  function automatic logic [D-1:0] fold(logic [1:0] op, logic [N-1:0] m, logic [D-1:0] d [N]);
    logic [D-1:0] r;
    r = (op == 2'b01) ? '1 : '0;
    for (int i = 0; i < N; i++)
      if (m[i]) begin
        case (op)
          2'b00: r = D'(int'(r) + int'(d[i]));
          2'b01: r = r & d[i];
          2'b10: r = r | d[i];
          default: if (d[i] > r) r = d[i];
        endcase
      end
    return r;
  endfunction

  task automatic drive_on(int i, logic [A-1:0] a, logic red, logic [N-1:0] m,
                          logic [1:0] op, logic [D-1:0] d);
    up_aw_valid[i] = 1'b1; up_w_valid[i] = 1'b1;
    up_aw_addr[i*A +: A] = a; up_aw_red[i] = red;
    up_aw_mask[i*N +: N] = m; up_aw_op[2*i +: 2] = op;
    up_w_data[i*D +: D] = d;
  endtask

  task automatic drive_off(int i);
    up_aw_valid[i] = 1'b0; up_w_valid[i] = 1'b0;
  endtask

  // bad: 0 none, 1 address, 2 mask, 3 operator (applied to the highest participant)
  task automatic run_red(logic [N-1:0] m, logic [1:0] op, logic [A-1:0] base, int seed,
                         int bad, logic [1:0] rsp);
    logic [D-1:0] d [N];
    logic [D-1:0] exp_d;
    logic [1:0]   exp_r;
    int aw0, rs0, hi, left, cnt;
    int bc0 [N];
    aw0 = mon_aw_cnt; rs0 = rsp_sent; hi = 0; left = $countones(m);
    for (int i = 0; i < N; i++) begin d[i] = pat(seed, i); bc0[i] = b_cnt[i]; if (m[i]) hi = i; end
    exp_d = fold(op, m, d);
    exp_r = (bad != 0) ? 2'b10 : rsp;
    rsp_next = rsp;
    up_b_ready = '0;
    for (int i = 0; i < N; i++) begin
      if (m[i]) begin
        @(negedge clk);
        drive_on(i, (bad == 1 && i == hi) ? base ^ 16'h0100 : base, 1'b1,
                 (bad == 2 && i == hi) ? m ^ 3'b001 : m,
                 (bad == 3 && i == hi) ? op ^ 2'b01 : op, d[i]);
        @(negedge clk);
        drive_off(i);
        left--;
        chk(!up_aw_ready[i] && !up_w_ready[i], "R2", "ready after capture", {up_aw_ready, up_w_ready}, 0);
        if (left > 0) chk(!dn_aw_valid && !dn_w_valid, "R3", "early forward", {dn_aw_valid, dn_w_valid}, 0);
      end
    end
    cnt = 0;
    if (bad == 0) while (rsp_sent == rs0 && cnt < 40) begin @(negedge clk); cnt++; end
    else while (up_b_valid != m && cnt < 20) begin @(negedge clk); cnt++; end
    for (int i = 0; i < N; i++) begin
      if (m[i]) begin
        chk(up_b_valid[i] == 1'b1, "R7", "b valid held before ready", up_b_valid, m);
        up_b_ready[i] = 1'b1;
        @(negedge clk);
      end
    end
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) begin
      chk(b_cnt[i] - bc0[i] == (m[i] ? 1 : 0), "R6", "response count", b_cnt[i] - bc0[i], m[i]);
      if (m[i]) chk(b_last[i] == exp_r, (bad != 0) ? "R8" : "R6", "response code", b_last[i], exp_r);
    end
    chk(mon_aw_cnt - aw0 == ((bad != 0) ? 0 : 1), (bad != 0) ? "R8" : "R5", "downstream writes",
        mon_aw_cnt - aw0, (bad != 0) ? 0 : 1);
    if (bad == 0) begin
      chk(log_a[aw0 & 255] == base, "R4", "merged address", log_a[aw0 & 255], base);
      chk(log_d[aw0 & 255] == exp_d, "R4", "merged data", log_d[aw0 & 255], exp_d);
    end
    up_b_ready = '1;
  endtask

  task automatic run_uni(logic [N-1:0] m, int seed, logic [1:0] rsp);
    int aw0, rs0, k, cnt;
    int bc0 [N];
    aw0 = mon_aw_cnt; rs0 = rsp_sent; rsp_next = rsp;
    for (int i = 0; i < N; i++) bc0[i] = b_cnt[i];
    @(negedge clk);
    for (int i = 0; i < N; i++)
      if (m[i]) drive_on(i, 16'h8000 + A'(seed * 16 + i), 1'b0, 3'b111, 2'b11, pat(seed, i));
    @(negedge clk);
    for (int i = 0; i < N; i++) drive_off(i);
    cnt = 0;
    while (rsp_sent - rs0 < $countones(m) && cnt < 80) begin @(negedge clk); cnt++; end
    repeat (3) @(negedge clk);
    k = 0;
    for (int i = 0; i < N; i++) begin
      chk(b_cnt[i] - bc0[i] == (m[i] ? 1 : 0), "R9", "unicast response count", b_cnt[i] - bc0[i], m[i]);
      if (m[i]) begin
        chk(b_last[i] == rsp, "R9", "unicast response code", b_last[i], rsp);
        chk(log_a[(aw0 + k) & 255] == 16'h8000 + A'(seed * 16 + i), "R10", "unicast order address",
            log_a[(aw0 + k) & 255], 16'h8000 + A'(seed * 16 + i));
        chk(log_d[(aw0 + k) & 255] == pat(seed, i), "R9", "unicast data", log_d[(aw0 + k) & 255], pat(seed, i));
        k++;
      end
    end
  endtask

  initial begin
    up_aw_valid = '0; up_w_valid = '0; up_aw_red = '0; up_aw_addr = '0;
    up_aw_mask = '0; up_aw_op = '0; up_w_data = '0; up_b_ready = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(up_aw_ready == '1 && up_w_ready == '1, "R1", "upstream ready", {up_aw_ready, up_w_ready}, 6'h3f);
    chk(up_b_valid == '0, "R1", "response valid", up_b_valid, 0);
    chk(!dn_aw_valid && !dn_w_valid, "R1", "downstream valid", {dn_aw_valid, dn_w_valid}, 0);

    // R3 R4 sweep: every operator, every participant set, two data seeds
    for (int op = 0; op < 4; op++)
      for (int m = 1; m < 8; m++)
        for (int s = 0; s < 2; s++)
          run_red(3'(m), 2'(op), 16'h1000 + 16'(op * 64 + m * 4 + s), op * 100 + m * 7 + s * 31,
                  0, 2'((op + m + s) % 4));

    // R8 mismatches
    run_red(3'b111, 2'b00, 16'h2000, 5, 1, 2'b00);
    run_red(3'b011, 2'b01, 16'h2100, 6, 2, 2'b00);
    run_red(3'b110, 2'b11, 16'h2200, 7, 3, 2'b01);
    run_red(3'b101, 2'b10, 16'h2300, 8, 1, 2'b11);

    // R9 R10 unicast sweep
    for (int m = 1; m < 8; m++) run_uni(3'(m), m + 20, 2'(m % 4));

    // R9: unicast proceeds while a reduction is still collecting
    begin
      int aw0, rs0, cnt;
      int bc0 [N];
      aw0 = mon_aw_cnt; rs0 = rsp_sent; rsp_next = 2'b00;
      for (int i = 0; i < N; i++) bc0[i] = b_cnt[i];
      @(negedge clk);
      drive_on(0, 16'h4000, 1'b1, 3'b011, 2'b10, 16'h00f0);
      drive_on(2, 16'h2222, 1'b0, 3'b000, 2'b00, 16'h1234);
      @(negedge clk);
      drive_off(0); drive_off(2);
      cnt = 0;
      while (rsp_sent == rs0 && cnt < 40) begin @(negedge clk); cnt++; end
      repeat (3) @(negedge clk);
      chk(mon_aw_cnt - aw0 == 1 && log_a[aw0 & 255] == 16'h2222, "R9", "unicast during collection",
          log_a[aw0 & 255], 16'h2222);
      chk(b_cnt[0] == bc0[0] && b_cnt[2] == bc0[2] + 1, "R9", "response only to issuer",
          {b_cnt[0] - bc0[0], b_cnt[2] - bc0[2]}, 1);
      // R10: reduction completes in the same edge as a new unicast arrives
      aw0 = mon_aw_cnt; rs0 = rsp_sent; rsp_next = 2'b01;
      @(negedge clk);
      drive_on(1, 16'h4000, 1'b1, 3'b011, 2'b10, 16'h0f00);
      drive_on(2, 16'h3333, 1'b0, 3'b000, 2'b00, 16'h5678);
      @(negedge clk);
      drive_off(1); drive_off(2);
      cnt = 0;
      while (rsp_sent - rs0 < 2 && cnt < 80) begin @(negedge clk); cnt++; end
      repeat (3) @(negedge clk);
      chk(log_a[aw0 & 255] == 16'h4000, "R10", "reduction first", log_a[aw0 & 255], 16'h4000);
      chk(log_d[aw0 & 255] == 16'h0ff0, "R4", "or merge", log_d[aw0 & 255], 16'h0ff0);
      chk(log_a[(aw0 + 1) & 255] == 16'h3333, "R10", "unicast second", log_a[(aw0 + 1) & 255], 16'h3333);
      chk(b_cnt[0] == bc0[0] + 1 && b_cnt[1] == bc0[1] + 1 && b_cnt[2] == bc0[2] + 2, "R6",
          "responses after priority case", {b_cnt[0] - bc0[0], b_cnt[1] - bc0[1], b_cnt[2] - bc0[2]}, 0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule